// File: doc/BRIEF.md
# Keyed Software Reset Controller

This block turns one 32-bit control word into a set of independent, active-high reset lines for the modules around it. Software owns the word. It reads the word back, sets or clears the bits it wants, and writes the word again. Each bit position drives the reset line with the same index.

The upper byte of every write must carry a fixed guard value, 0x88. Without it the whole write is dropped. A stray store therefore cannot pull a module into reset. Because the guard shares the word with the reset bits, a read-modify-write sequence has to put the guard back in on every store. The guard byte always reads as zero.

To pulse a module, software makes two keyed writes: one that sets the line's bit and one that clears it. The number of lines that actually exist is a parameter of each instance.

Top module: `krst_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every line is cleared, so after reset all `rst_lines` are 0 and the register reads back as 0.
- R2: A write (`wr_en` high) to address `REG_OFFSET` (default 0x18) whose bits [31:24] equal 0x88 loads bits [NUM_LINES-1:0] of `wr_data` into the register. `rst_lines` shows the new value from the clock edge that accepts the write.
- R3: A write to `REG_OFFSET` whose bits [31:24] differ from 0x88 is discarded, and every line keeps its previous value.
- R4: A write to any address other than `REG_OFFSET` is ignored, whatever its key.
- R5: With `addr` equal to `REG_OFFSET`, `rd_data` returns the current register in bits [NUM_LINES-1:0] and zero in bits [31:24]. At any other address, `rd_data` is all zero.
- R6: Bits NUM_LINES through 23 of `wr_data` have no effect on any line and always read as zero.
- R7: Each `rst_lines[i]` is active high and equals register bit i. A line set by one keyed write stays high until a keyed write clears it, so a set write followed by a clear write makes a reset pulse on that line alone.
- R8: In a cycle where `wr_en` is low, no line changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| addr | input | ADDR_W | Register address, used for both write and read |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write word: guard in [31:24], line bits below |
| rd_data | output | 32 | Readback word, zero-extended |
| rst_lines | output | NUM_LINES | Active-high reset outputs, one per line |

## Verification
A corrupted register bit shows up at once on the matching `rst_lines` pin, and at the same moment in `rd_data`, in the cycle after the write that caused it. Every write is therefore followed by a compare of both the pins and the readback against a bench model.

A faulty guard or address decode would let a rejected write change some line one edge later. The bench sweeps all 256 guard values and all 256 addresses against a known background value. It also sweeps every data pattern for the small configuration. This exposes a wrong bit as soon as the write that touches it lands.

// File: rtl/krst_pkg.sv
package krst_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned GUARD_W   = 8;
    localparam int unsigned FIELD_W   = WORD_W - GUARD_W;
    localparam logic [GUARD_W-1:0] GUARD_VALUE = 8'h88;

    typedef struct packed {
        logic [GUARD_W-1:0] guard;
        logic [FIELD_W-1:0] field;
    } krst_word_t;

    function automatic logic guard_ok(input logic [GUARD_W-1:0] g);
        return g == GUARD_VALUE;
    endfunction

endpackage

// File: rtl/krst_wr_decode.sv
module krst_wr_decode
    import krst_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h18
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [GUARD_W-1:0] guard,
    output logic               sel,
    output logic               load
);

    always_comb begin
        sel  = (addr == REG_OFFSET);
        load = wr_en && sel && guard_ok(guard);
    end

endmodule

// File: rtl/krst_line_bit.sv
module krst_line_bit (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/krst_readback.sv
module krst_readback
    import krst_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 sel,
    input  logic [NUM_LINES-1:0] lines,
    output logic [WORD_W-1:0]    rd_data
);

    krst_word_t word;

    always_comb begin
        word       = '0;
        word.field[NUM_LINES-1:0] = lines;
        rd_data    = sel ? word : '0;
    end

endmodule

// File: rtl/krst_ctrl.sv
module krst_ctrl
    import krst_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [31:0]          wr_data,
    output logic [31:0]          rd_data,
    output logic [NUM_LINES-1:0] rst_lines
);

    krst_word_t wr_word;
    logic       reg_sel;
    logic       reg_load;

    assign wr_word = wr_data;

    krst_wr_decode #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_decode (
        .addr  (addr),
        .wr_en (wr_en),
        .guard (wr_word.guard),
        .sel   (reg_sel),
        .load  (reg_load)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        krst_line_bit u_bit (
            .clk  (clk),
            .rst  (rst),
            .load (reg_load),
            .d    (wr_word.field[i]),
            .q    (rst_lines[i])
        );
    end

    if (NUM_LINES < FIELD_W) begin : g_spare
        logic unused_spare;
        assign unused_spare = ^wr_word.field[FIELD_W-1:NUM_LINES];
    end

    krst_readback #(
        .NUM_LINES (NUM_LINES)
    ) u_readback (
        .sel     (reg_sel),
        .lines   (rst_lines),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/krst_ctrl_chk.sv
module krst_ctrl_chk #(
    parameter int unsigned NUM_LINES  = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h18
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    addr,
    input logic                 wr_en,
    input logic [31:0]          wr_data,
    input logic [31:0]          rd_data,
    input logic [NUM_LINES-1:0] rst_lines
);

    logic [31:0] upper_mask;
    always_comb begin
        upper_mask = '1;
        upper_mask[NUM_LINES-1:0] = '0;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> rst_lines == '0) // R1
        else $error("reset clear");

    AST_KEYED_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_OFFSET && wr_data[31:24] == 8'h88)
        |=> rst_lines == $past(wr_data[NUM_LINES-1:0])) // R2
        else $error("keyed load");

    AST_BAD_GUARD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31:24] != 8'h88) |=> $stable(rst_lines)) // R3
        else $error("bad guard");

    AST_OTHER_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr != REG_OFFSET) |=> $stable(rst_lines)) // R4
        else $error("other addr");

    AST_READ_MATCH: assert property (@(posedge clk) disable iff (rst)
        (addr == REG_OFFSET) |-> rd_data[NUM_LINES-1:0] == rst_lines) // R5
        else $error("readback");

    AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data & upper_mask) == 32'h0) // R6
        else $error("upper bits");

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rst_lines)) // R8
        else $error("idle hold");

endmodule

bind krst_ctrl krst_ctrl_chk #(
    .NUM_LINES  (NUM_LINES),
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .rst_lines (rst_lines)
);

// File: tb/krst_ctrl_tb.sv
module krst_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam logic [7:0] OFF = 8'h18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   addr = OFF;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  rd_data;
    logic [N-1:0] rst_lines;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] model;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    krst_ctrl #(.NUM_LINES(N), .ADDR_W(8), .REG_OFFSET(OFF)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .rst_lines(rst_lines)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = OFF;
        #1;
    endtask

    task automatic check_state(input string req);
        addr = OFF; #1;
        check(req, {24'h0, rst_lines}, {24'h0, model});
        check(req, rd_data, {24'h0, model});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        model = '0;
        check_state("R1");

        // R2 sweep every pattern with the guard
        for (int v = 0; v < 256; v++) begin
            wr(OFF, {8'h88, 16'h0, v[7:0]});
            model = v[7:0];
            check_state("R2");
        end

        // R3 sweep every guard value against a known background
        for (int k = 0; k < 256; k++) begin
            wr(OFF, 32'h880000A5); model = 8'hA5;
            wr(OFF, {k[7:0], 16'h0, 8'h5A});
            if (k[7:0] == 8'h88) model = 8'h5A;
            check_state("R3");
        end

        // R4 sweep every address with a valid guard
        for (int a = 0; a < 256; a++) begin
            wr(OFF, 32'h8800003C); model = 8'h3C;
            wr(a[7:0], 32'h880000C3);
            if (a[7:0] == OFF) model = 8'hC3;
            check_state("R4");
        end

        // R5 readback at other addresses is zero
        for (int a = 0; a < 256; a++) begin
            addr = a[7:0]; #1;
            check("R5", rd_data, (a[7:0] == OFF) ? {24'h0, model} : 32'h0);
        end

        // R6 spare bits ignored
        wr(OFF, 32'h88FFFF00); model = 8'h00;
        check_state("R6");
        wr(OFF, 32'h88ABCD81); model = 8'h81;
        check_state("R6");

        // R7 read-modify-write pulse on each line
        wr(OFF, 32'h88000000); model = '0;
        for (int i = 0; i < N; i++) begin
            addr = OFF; #1;
            wr(OFF, 32'h88000000 | (rd_data[23:0] | (24'h1 << i)));
            model[i] = 1'b1;
            check_state("R7");
            repeat (3) @(negedge clk);
            #1;
            check("R7", {24'h0, rst_lines}, {24'h0, model});
            addr = OFF; #1;
            wr(OFF, 32'h88000000 | (rd_data[23:0] & ~(24'h1 << i)));
            model[i] = 1'b0;
            check_state("R7");
        end

        // R8 no write strobe, data and key present
        wr(OFF, 32'h88000055); model = 8'h55;
        @(negedge clk);
        addr = OFF; wr_data = 32'h880000AA; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check_state("R8");

        // R1 again mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        model = '0;
        check_state("R1");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule